// File: doc/BRIEF.md
# Interval Block Exponent Normalizer

This block prepares a block of interval samples for block floating point processing. Each sample carries a lower and an upper endpoint, each a 16-bit two's complement word in Q7.8 format. The block reads the samples twice. In the first pass it measures the headroom of every endpoint, which is the number of redundant sign bits, and keeps the smallest value found across the block. In the second pass it shifts every endpoint left by that common amount, so the block uses the full word without changing any sign. It also publishes the new block exponent, which is the incoming exponent less the shift.

A block opens with a valid sample that carries the start marker. That sample and the next N-1 valid samples make up the detection pass. The N valid samples that follow are the same block, supplied again, and they are normalized one at a time with a one-cycle latency. The block does not store samples, so the source must supply the block a second time. Cycles without valid data may fall anywhere in either pass.

Top module: `bfp_normalizer`

## Requirements
- R1: The redundant sign bit count of a word is the number of bits below the MSB that equal the MSB before the first bit that differs. It is found by XORing adjacent bits and priority-encoding the highest set bit. A word of all zeros or all ones counts 15, the largest shift allowed.
- R2: The common shift is the smallest count over both the lower and the upper endpoint of all N samples of the detection pass.
- R3: A block starts only on a cycle with in_valid and in_start both high while no block is in progress. That sample and the next N-1 valid cycles form the detection pass. Cycles with in_valid low are not counted.
- R4: On the clock edge that takes the last detection sample, exp_out is loaded with the exp_in captured with the start sample minus the common shift, in 8-bit two's complement. exp_out then holds until the next block's detection pass ends. The value of exp_in on any other cycle has no effect.
- R5: In the normalization pass, the next N valid samples each produce out_valid high one cycle later. On that cycle out_lo and out_hi are the input endpoints shifted left by the common shift, with zeros filled in at the bottom.
- R6: A normalized endpoint always keeps the sign bit of its input endpoint.
- R7: done is a one-cycle pulse in the cycle after the N-th normalized sample appears on the outputs.
- R8: in_start is ignored while a block is in progress. In_valid without in_start while idle produces no output and does not start a block.
- R9: After reset, out_valid, done and exp_out are all zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input sample is valid this cycle |
| in_start | input | 1 | Marks the first sample of a new block |
| in_lo | input | 16 | Lower endpoint of the input sample |
| in_hi | input | 16 | Upper endpoint of the input sample |
| exp_in | input | 8 | Current block exponent, captured with the start sample |
| out_valid | output | 1 | A normalized sample is on the outputs |
| out_lo | output | 16 | Normalized lower endpoint |
| out_hi | output | 16 | Normalized upper endpoint |
| exp_out | output | 8 | Updated block exponent |
| done | output | 1 | Pulse after the last normalized sample of a block |

## Verification
The new exponent is due on the cycle after the edge that takes the last detection sample. A normalized sample is due one cycle after its input is accepted, and done is due one cycle after that sample. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, and the outputs are compared with the model at every falling edge. Each result is therefore checked in exactly the cycle it is due, and never earlier or later. Directed blocks add fixed expected exponents for the hand-worked case, the all-zero block and the full-scale block. Idle valid data and a mid-block start marker are also covered.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    localparam int DEF_W  = 16;
    localparam int DEF_N  = 4;
    localparam int DEF_EW = 8;

    typedef enum logic [1:0] {PH_IDLE, PH_DETECT, PH_NORM} phase_e;

    typedef struct packed {
        logic vld;
        logic last;
    } out_tag_t;

    function automatic int unsigned umin(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/bfp_sign_count.sv
module bfp_sign_count #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);
    logic [W-2:0] diff;

    generate
        for (genvar g = 0; g < W - 1; g++) begin : g_xor
            assign diff[g] = word[g+1] ^ word[g];
        end
    endgenerate

    // highest differing pair wins; none differing gives the full W-1
    always_comb begin
        count = CW'(W - 1);
        for (int i = 0; i < W - 1; i++) begin
            if (diff[i]) count = CW'(W - 2 - i);
        end
    end

    logic [W-1:0] roundtrip;
    always_comb begin
        roundtrip = W'($signed(word << count) >>> count);
        p_lossless_r1: assert (roundtrip == word)
            else $error("sign count too large for word %h", word);
    end
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  shifted
);
    localparam int NC = 2 ** CW;
    logic [W-1:0] cand [NC];

    generate
        for (genvar g = 0; g < NC; g++) begin : g_copy
            if (g < W) begin : g_live
                assign cand[g] = word << g;
            end else begin : g_pad
                assign cand[g] = '0;
            end
        end
    endgenerate

    assign shifted = cand[amt];
endmodule

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
    import bfp_pkg::*;
#(
    parameter int W   = 16,
    parameter int N   = 4,
    parameter int EW  = 8,
    parameter int CW  = $clog2(W),
    parameter int NCW = $clog2(N) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [EW-1:0] exp_in,
    input  logic [CW-1:0] cnt_lo,
    input  logic [CW-1:0] cnt_hi,
    output phase_e        phase,
    output logic [CW-1:0] shift_amt,
    output logic [EW-1:0] exp_out,
    output logic          norm_take,
    output logic          norm_last
);
    logic [NCW-1:0] idx;
    logic [CW-1:0]  run_min;
    logic [EW-1:0]  exp_q;

    logic           first, det_fire, det_last;
    logic [CW-1:0]  sample_min, cand_min;
    logic [NCW-1:0] pos;
    logic [EW-1:0]  base_exp;

    always_comb begin
        first      = (phase == PH_IDLE);
        det_fire   = in_valid && ((first && in_start) || phase == PH_DETECT);
        sample_min = CW'(umin(int'(cnt_lo), int'(cnt_hi)));
        cand_min   = first ? sample_min : CW'(umin(int'(run_min), int'(sample_min)));
        pos        = first ? '0 : idx;
        det_last   = det_fire && (pos == NCW'(N - 1));
        base_exp   = first ? exp_in : exp_q;
        norm_take  = in_valid && (phase == PH_NORM);
        norm_last  = norm_take && (idx == NCW'(N - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            idx       <= '0;
            run_min   <= CW'(W - 1);
            exp_q     <= '0;
            exp_out   <= '0;
            shift_amt <= '0;
        end else if (det_fire) begin
            run_min <= cand_min;
            if (first) exp_q <= exp_in;
            if (det_last) begin
                phase     <= PH_NORM;
                idx       <= '0;
                shift_amt <= cand_min;
                exp_out   <= base_exp - EW'(cand_min);
            end else begin
                phase <= PH_DETECT;
                idx   <= pos + NCW'(1);
            end
        end else if (norm_take) begin
            if (norm_last) begin
                phase <= PH_IDLE;
                idx   <= '0;
            end else begin
                idx <= idx + NCW'(1);
            end
        end
    end

    // running minimum never grows inside a detection pass
    p_min_falls_r2: assert property (@(posedge clk) disable iff (rst)
        (det_fire && phase == PH_DETECT) |=> (run_min <= $past(run_min)));

    // exponent is frozen while a block is being normalized
    p_exp_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_NORM && $past(phase) == PH_NORM) |-> $stable(exp_out));

    // a start marker during normalization does not restart detection
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_NORM && !norm_last) |=> (phase == PH_NORM));
endmodule

// File: rtl/bfp_normalizer.sv
module bfp_normalizer
    import bfp_pkg::*;
#(
    parameter int W  = DEF_W,
    parameter int N  = DEF_N,
    parameter int EW = DEF_EW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [W-1:0]  in_lo,
    input  logic [W-1:0]  in_hi,
    input  logic [EW-1:0] exp_in,
    output logic          out_valid,
    output logic [W-1:0]  out_lo,
    output logic [W-1:0]  out_hi,
    output logic [EW-1:0] exp_out,
    output logic          done
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  ep_in  [2];
    logic [W-1:0]  ep_sh  [2];
    logic [CW-1:0] ep_cnt [2];
    logic [CW-1:0] shift_amt;
    logic          norm_take, norm_last;
    phase_e        phase;
    out_tag_t      tag_q;

    assign ep_in[0] = in_lo;
    assign ep_in[1] = in_hi;

    generate
        for (genvar e = 0; e < 2; e++) begin : g_ep
            bfp_sign_count #(.W(W), .CW(CW)) u_cnt (
                .word  (ep_in[e]),
                .count (ep_cnt[e])
            );
            bfp_shifter #(.W(W), .CW(CW)) u_sh (
                .word    (ep_in[e]),
                .amt     (shift_amt),
                .shifted (ep_sh[e])
            );
        end
    endgenerate

    bfp_ctrl #(.W(W), .N(N), .EW(EW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .exp_in    (exp_in),
        .cnt_lo    (ep_cnt[0]),
        .cnt_hi    (ep_cnt[1]),
        .phase     (phase),
        .shift_amt (shift_amt),
        .exp_out   (exp_out),
        .norm_take (norm_take),
        .norm_last (norm_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            out_lo <= '0;
            out_hi <= '0;
            done   <= 1'b0;
        end else begin
            tag_q.vld  <= norm_take;
            tag_q.last <= norm_last;
            done       <= tag_q.vld && tag_q.last;
            if (norm_take) begin
                out_lo <= ep_sh[0];
                out_hi <= ep_sh[1];
            end
        end
    end

    assign out_valid = tag_q.vld;

    p_sign_kept_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lo[W-1] == $past(in_lo[W-1]) && out_hi[W-1] == $past(in_hi[W-1])));

    p_done_after_out_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid) && !out_valid));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_out_from_norm_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(phase) == PH_NORM && $past(in_valid)));
endmodule

// File: tb/tb_bfp_normalizer.sv
module tb_bfp_normalizer;
    localparam int W  = 16;
    localparam int N  = 4;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_start = 1'b0;
    logic [W-1:0]  in_lo = '0, in_hi = '0;
    logic [EW-1:0] exp_in = '0;
    logic          out_valid, done;
    logic [W-1:0]  out_lo, out_hi;
    logic [EW-1:0] exp_out;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bfp_normalizer #(.W(W), .N(N), .EW(EW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_lo(in_lo), .in_hi(in_hi), .exp_in(exp_in),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
        .exp_out(exp_out), .done(done)
    );

    function automatic int rsb(logic [W-1:0] x);
        int c = 0;
        for (int i = W - 2; i >= 0; i--) begin
            if (x[i] == x[W-1]) c++;
            else break;
        end
        return c;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 detect, 2 normalize
    int            m_ph = 0, m_n = 0, m_min = 0;
    logic [EW-1:0] m_base = '0, m_exp = '0;
    bit            m_ov = 0, m_last = 0, m_done = 0;
    logic [W-1:0]  m_lo = '0, m_hi = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_n = 0; m_exp = '0; m_ov = 0; m_last = 0; m_done = 0;
        end else begin
            int smin;
            m_done = m_ov && m_last;
            m_ov = 0; m_last = 0;
            smin = (rsb(in_lo) < rsb(in_hi)) ? rsb(in_lo) : rsb(in_hi);
            if (in_valid && ((m_ph == 0 && in_start) || m_ph == 1)) begin
                if (m_ph == 0) begin
                    m_base = exp_in; m_min = smin; m_n = 1;
                end else begin
                    if (smin < m_min) m_min = smin;
                    m_n++;
                end
                m_ph = 1;
                if (m_n == N) begin
                    m_exp = m_base - EW'(m_min);
                    m_ph = 2; m_n = 0;
                end
            end else if (in_valid && m_ph == 2) begin
                m_ov = 1;
                m_lo = in_lo << m_min;
                m_hi = in_hi << m_min;
                m_n++;
                if (m_n == N) begin
                    m_last = 1; m_ph = 0; m_n = 0;
                end
            end
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(out_valid == m_ov, "R5", "out_valid", out_valid, m_ov);
            chk(done == m_done, "R7", "done", done, m_done);
            chk(exp_out == m_exp, "R4", "exp_out", exp_out, m_exp);
            if (m_ov) begin
                chk(out_lo == m_lo, "R5", "out_lo", out_lo, m_lo);
                chk(out_hi == m_hi, "R5", "out_hi", out_hi, m_hi);
                chk(out_lo[W-1] == m_lo[W-1] && out_hi[W-1] == m_hi[W-1], "R6", "sign", {out_lo[W-1], out_hi[W-1]}, {m_lo[W-1], m_hi[W-1]});
            end
        end
    end

    task automatic drive(bit v, bit s, logic [W-1:0] lo, logic [W-1:0] hi, logic [EW-1:0] e);
        @(negedge clk);
        in_valid = v; in_start = s; in_lo = lo; in_hi = hi; exp_in = e;
    endtask

    logic [W-1:0] blo [N];
    logic [W-1:0] bhi [N];

    task automatic run_block(logic [EW-1:0] e, bit gaps, bit mid_start);
        for (int i = 0; i < N; i++) begin
            drive(1, (i == 0) || (mid_start && i == 2), blo[i], bhi[i], (i == 0) ? e : 8'h5A);
            if (gaps && i[0]) drive(0, 0, 16'h1234, 16'h0001, 8'h77);
        end
        for (int i = 0; i < N; i++) begin
            drive(1, mid_start && i == 1, blo[i], bhi[i], 8'hA5);
            if (gaps && !i[0]) drive(0, 1, 16'h0000, 16'h0000, 8'h33);
        end
        drive(0, 0, '0, '0, '0);
        drive(0, 0, '0, '0, '0);
        drive(0, 0, '0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 0 && done == 0 && exp_out == 0, "R9", "reset outputs",
            {out_valid, done, exp_out}, 0);
        rst = 0;

        // R8: valid without start while idle gives nothing
        drive(1, 0, 16'h0100, 16'h0200, 8'h10);
        drive(1, 0, 16'h0300, 16'h0400, 8'h10);
        drive(0, 0, '0, '0, '0);
        @(negedge clk);
        chk(out_valid == 0 && exp_out == 0, "R8", "idle valid ignored", {out_valid, exp_out}, 0);

        // R1 R2: hand-worked block, minimum count 9 from 0x0030
        blo[0] = 16'h0008; bhi[0] = 16'h0030;
        blo[1] = 16'hFFE6; bhi[1] = 16'h0002;
        blo[2] = 16'h0000; bhi[2] = 16'h0000;
        blo[3] = 16'hFFFF; bhi[3] = 16'h0000;
        run_block(8'h00, 0, 0);
        chk(exp_out == 8'hF7, "R2", "example exponent -9", exp_out, 8'hF7);

        // R1: all-zero block shifts by 15
        for (int i = 0; i < N; i++) begin blo[i] = '0; bhi[i] = '0; end
        run_block(8'd3, 1, 0);
        chk(exp_out == 8'hF4, "R1", "zero block exponent 3-15", exp_out, 8'hF4);

        // R2: full-scale endpoint forces shift 0
        blo[0] = 16'h0001; bhi[0] = 16'h0002;
        blo[1] = 16'h8000; bhi[1] = 16'h0010;
        blo[2] = 16'hFFF0; bhi[2] = 16'h7FFF;
        blo[3] = 16'h0000; bhi[3] = 16'h0004;
        run_block(8'd5, 0, 1);
        chk(exp_out == 8'd5, "R2", "full-scale keeps exponent", exp_out, 8'd5);

        // R3 R4 R5 R8: varied blocks with gaps and stray start markers
        for (int b = 0; b < 30; b++) begin
            for (int i = 0; i < N; i++) begin
                blo[i] = W'($signed(W'($urandom)) >>> ($urandom % W));
                bhi[i] = W'($signed(W'($urandom)) >>> ($urandom % W));
            end
            run_block(EW'($urandom), b[0], b[1]);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule